// File: doc/BRIEF.md
# MAC Enable and Soft-Reset Controller

This block holds the run/stop state of an Ethernet MAC. Software writes a two-field control word: an enable field that lets both directions run, and a soft-reset field that starts a local reset of the MAC. Hardware may also drop the enable without software: a fatal transmit error or a fatal receive error clears it at once. The full control word reads back through a 32-bit read port. The soft-reset field reads as 1 while the local reset runs and clears by itself when the reset ends.

Stopping is deliberately uneven. The receive side is told to stop in the same cycle the enable drops. The transmit side is asked to close the frame it is sending with a corrupted CRC. It is only reported idle once it acknowledges that the frame has ended. A soft reset lasts a fixed number of cycles. It drives a reset-active output that returns the other MAC registers to their defaults. It also aborts any transmit at once, with no corrupted-CRC request. The datapaths and the CRC generator sit outside this block. Only their control and handshake lines appear here.

Top module: `mac_en_ctrl`

## Requirements
- R1: After rst_n is released, rd_data is 0, rx_run, tx_run, tx_bad_crc and local_rst are 0, and tx_idle is 1.
- R2: A write (wr_en high, no reset in progress) with wr_fields bit 1 = 1 and bit 0 = 0 sets the enable. From the next cycle rd_data bit 1 reads 1, rx_run and tx_run are 1, and rd_data bits 31..2 always read 0.
- R3: A write with wr_fields bit 1 = 0 clears the enable. rx_run is 0 in the very next cycle.
- R4: When the enable drops while tx_frame_active is 1, tx_bad_crc is 1 for exactly one cycle, the first cycle with the enable low. tx_idle then stays 0 until tx_eof_ack is seen, and it reads 1 in the cycle after that acknowledge.
- R5: When the enable drops while tx_frame_active is 0, tx_idle is 1 in the next cycle and no tx_bad_crc pulse is issued.
- R6: A write with wr_fields bit 0 = 1 drives local_rst high for exactly RST_CYCLES (default 8) cycles, starting the cycle after the write. During that time rd_data bit 0 reads 1 and the enable reads 0. Afterwards bit 0 reads 0.
- R7: Writes made while local_rst is high are ignored. They neither set the enable nor restart or stretch the reset.
- R8: A write with both fields set to 1 starts the reset and leaves the enable cleared.
- R9: tx_fatal_err or rx_fatal_err high in a cycle clears the enable in the next cycle. This holds even when a write setting the enable arrives in the same cycle.
- R10: A soft reset aborts the transmit side. tx_idle is 1 in the next cycle and no tx_bad_crc pulse is issued, even if a frame was active or was being finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_fields | input | 2 | Write data: bit 1 enable, bit 0 soft reset |
| rd_data | output | 32 | Control word readback |
| tx_fatal_err | input | 1 | Fatal transmit error flag |
| rx_fatal_err | input | 1 | Fatal receive error flag |
| tx_frame_active | input | 1 | Transmit path is sending a frame |
| tx_eof_ack | input | 1 | Transmit path has ended the frame being closed |
| rx_run | output | 1 | Receive path may run |
| tx_run | output | 1 | Transmit path may start and send frames |
| tx_bad_crc | output | 1 | One-cycle request to end the current frame with a corrupted CRC |
| tx_idle | output | 1 | Transmit path is stopped |
| local_rst | output | 1 | Local reset of the MAC registers is in progress |

## Verification
The transmit-side assertions assume that the transmit path raises tx_eof_ack only while it is closing a frame. That is the window after a corrupted-CRC request, in which neither tx_run nor tx_idle is high. They also assume that every input is at a known level once reset is released. The random stimulus meets the first assumption by gating tx_eof_ack on the observed outputs, so it is raised only when tx_run and tx_idle are both low. Every input is driven to a defined value from time zero. Writes, error flags and frame activity are otherwise drawn freely, so resets overlap writes, errors and frames being closed.

// File: rtl/mec_pkg.sv
package mec_pkg;
    localparam int unsigned EN_BIT   = 1;
    localparam int unsigned SRST_BIT = 0;
    localparam int unsigned FIELD_W  = 2;

    typedef enum logic [1:0] {
        TXS_IDLE   = 2'd0,
        TXS_RUN    = 2'd1,
        TXS_FINISH = 2'd2
    } txs_e;
endpackage

// File: rtl/mec_rst_seq.sv
module mec_rst_seq #(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.cnt = CNT_W'(RST_CYCLES);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.cnt != '0);

    // R6: an accepted reset request makes the sequence active next cycle
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7: no new request may be accepted while the sequence runs
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/mec_ctrl_reg.sv
module mec_ctrl_reg
    import mec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_fields,
    input  logic               busy,
    input  logic               tx_fatal,
    input  logic               rx_fatal,
    output logic               start,
    output logic               en_nxt,
    output logic               en,
    output logic [DATA_W-1:0]  rd_data
);
    typedef struct packed {
        logic en;
    } ctl_t;

    ctl_t c_d, c_q;
    logic accept;

    always_comb begin
        accept = wr_en && !busy;
        start  = accept && wr_fields[SRST_BIT];
        c_d    = c_q;
        if (start) begin
            c_d.en = 1'b0;
        end else if (tx_fatal || rx_fatal) begin
            c_d.en = 1'b0;
        end else if (accept) begin
            c_d.en = wr_fields[EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign en_nxt = c_d.en;
    assign en     = c_q.en;

    always_comb begin
        rd_data           = '0;
        rd_data[EN_BIT]   = c_q.en;
        rd_data[SRST_BIT] = busy;
    end

    // R2: a plain enable write with no error sets the enable
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_fields == 2'b10 && !tx_fatal && !rx_fatal) |=> en);

    // R8: a reset request always leaves the enable cleared
    a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !en);

    // R9: any fatal error flag clears the enable next cycle
    a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fatal || rx_fatal) |=> !en);

    // R6: the enable stays off for the whole reset sequence
    a_r6_off_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !en);
endmodule

// File: rtl/mec_tx_stop.sv
module mec_tx_stop
    import mec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_nxt,
    input  logic abort,
    input  logic frame_active,
    input  logic eof_ack,
    output logic tx_run,
    output logic tx_idle,
    output logic bad_crc
);
    typedef struct packed {
        txs_e st;
        logic crc;
    } txc_t;

    txc_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.crc = 1'b0;
        unique case (t_q.st)
            TXS_IDLE: begin
                if (en_nxt) t_d.st = TXS_RUN;
            end
            TXS_RUN: begin
                if (!en_nxt) begin
                    if (abort) begin
                        t_d.st = TXS_IDLE;
                    end else if (frame_active) begin
                        t_d.st  = TXS_FINISH;
                        t_d.crc = 1'b1;
                    end else begin
                        t_d.st = TXS_IDLE;
                    end
                end
            end
            TXS_FINISH: begin
                if (abort || eof_ack) t_d.st = TXS_IDLE;
            end
            default: t_d.st = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{st: TXS_IDLE, crc: 1'b0};
        else        t_q <= t_d;
    end

    assign tx_run  = (t_q.st == TXS_RUN);
    assign tx_idle = (t_q.st == TXS_IDLE);
    assign bad_crc = t_q.crc;

    // R4: the corrupted-CRC request lasts a single cycle
    a_r4_crc_single: assert property (@(posedge clk) disable iff (!rst_n)
        bad_crc |=> !bad_crc);

    // R4: the request is only raised while a frame is being closed
    a_r4_crc_in_finish: assert property (@(posedge clk) disable iff (!rst_n)
        bad_crc |-> (!tx_idle && !tx_run));

    // R4: idle is not reported before the end-of-frame acknowledge
    a_r4_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_idle && !tx_run && !eof_ack && !abort) |=> !tx_idle);

    // R10: an abort stops the transmit side with no CRC request
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (tx_idle && !bad_crc));
endmodule

// File: rtl/mac_en_ctrl.sv
module mac_en_ctrl
    import mec_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_fields,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               tx_fatal_err,
    input  logic               rx_fatal_err,
    input  logic               tx_frame_active,
    input  logic               tx_eof_ack,
    output logic               rx_run,
    output logic               tx_run,
    output logic               tx_bad_crc,
    output logic               tx_idle,
    output logic               local_rst
);
    logic busy;
    logic start;
    logic en_nxt;
    logic en;

    mec_rst_seq #(.RST_CYCLES(RST_CYCLES)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    mec_ctrl_reg #(.DATA_W(DATA_W)) reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_fields (wr_fields),
        .busy      (busy),
        .tx_fatal  (tx_fatal_err),
        .rx_fatal  (rx_fatal_err),
        .start     (start),
        .en_nxt    (en_nxt),
        .en        (en),
        .rd_data   (rd_data)
    );

    mec_tx_stop txs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_nxt       (en_nxt),
        .abort        (start),
        .frame_active (tx_frame_active),
        .eof_ack      (tx_eof_ack),
        .tx_run       (tx_run),
        .tx_idle      (tx_idle),
        .bad_crc      (tx_bad_crc)
    );

    assign rx_run    = en;
    assign local_rst = busy;

    // R3: receive permission drops in the cycle after a clearing write
    a_r3_rx_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !local_rst && !wr_fields[EN_BIT]) |=> !rx_run);

    // R2: reserved readback bits stay zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:FIELD_W] == '0);

    // R6: while reset runs, its readback bit is set and the enable is clear
    a_r6_readback: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst |-> (rd_data[SRST_BIT] && !rd_data[EN_BIT]));
endmodule

// File: tb/mac_en_ctrl_tb_top.sv
module mac_en_ctrl_tb_top;
    localparam int unsigned RST_N_CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_fields = 2'b00;
    logic [31:0] rd_data;
    logic        tx_fatal_err = 1'b0;
    logic        rx_fatal_err = 1'b0;
    logic        tx_frame_active = 1'b0;
    logic        tx_eof_ack = 1'b0;
    logic        rx_run, tx_run, tx_bad_crc, tx_idle, local_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mac_en_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_fields       (wr_fields),
        .rd_data         (rd_data),
        .tx_fatal_err    (tx_fatal_err),
        .rx_fatal_err    (rx_fatal_err),
        .tx_frame_active (tx_frame_active),
        .tx_eof_ack      (tx_eof_ack),
        .rx_run          (rx_run),
        .tx_run          (tx_run),
        .tx_bad_crc      (tx_bad_crc),
        .tx_idle         (tx_idle),
        .local_rst       (local_rst)
    );

    // Expected-state model, built from the requirements
    logic       m_en = 1'b0;
    int         m_cnt = 0;
    int         m_st = 0;      // 0 idle, 1 run, 2 finishing
    logic       m_crc = 1'b0;

    always @(posedge clk) begin
        logic go;
        logic en_n;
        if (!rst_n) begin
            m_en <= 1'b0; m_cnt <= 0; m_st <= 0; m_crc <= 1'b0;
        end else begin
            go   = wr_en && (m_cnt == 0) && wr_fields[0];
            en_n = m_en;
            if (go) en_n = 1'b0;
            else if (tx_fatal_err || rx_fatal_err) en_n = 1'b0;
            else if (wr_en && m_cnt == 0) en_n = wr_fields[1];
            m_en  <= en_n;
            m_cnt <= go ? RST_N_CYC : (m_cnt != 0 ? m_cnt - 1 : 0);
            m_crc <= 1'b0;
            case (m_st)
                0: if (en_n) m_st <= 1;
                1: if (!en_n) begin
                       if (go) m_st <= 0;
                       else if (tx_frame_active) begin m_st <= 2; m_crc <= 1'b1; end
                       else m_st <= 0;
                   end
                default: if (go || tx_eof_ack) m_st <= 0;
            endcase
        end
    end

    function automatic logic [31:0] exp_rd(input logic en, input int cnt);
        return {30'd0, en, (cnt != 0)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] f);
        wr_en = 1'b1; wr_fields = f;
        @(negedge clk);
        wr_en = 1'b0; wr_fields = 2'b00;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 idle", {rx_run, tx_run, tx_bad_crc, tx_idle, local_rst}, 5'b00010);

        // R2 enable set
        do_write(2'b10);
        chk("R2 rd_data", rd_data, 32'h2);
        chk("R2 run", {rx_run, tx_run, tx_idle}, 3'b110);

        // R3 / R4 disable with a frame in flight
        tx_frame_active = 1'b1;
        do_write(2'b00);
        chk("R3 rx stops", rx_run, 1'b0);
        chk("R4 crc pulse", {tx_bad_crc, tx_idle, tx_run}, 3'b100);
        @(negedge clk);
        chk("R4 crc one cycle", tx_bad_crc, 1'b0);
        repeat (3) @(negedge clk);
        chk("R4 waits ack", tx_idle, 1'b0);
        tx_eof_ack = 1'b1;
        @(negedge clk);
        tx_eof_ack = 1'b0; tx_frame_active = 1'b0;
        chk("R4 idle after ack", tx_idle, 1'b1);

        // R5 disable with no frame
        do_write(2'b10);
        do_write(2'b00);
        chk("R5 idle no crc", {tx_idle, tx_bad_crc, rx_run}, 3'b100);

        // R9 error clears, and wins over a same-cycle enable write
        do_write(2'b10);
        tx_fatal_err = 1'b1;
        @(negedge clk);
        tx_fatal_err = 1'b0;
        chk("R9 tx error clears", rd_data, 32'h0);
        rx_fatal_err = 1'b1; wr_en = 1'b1; wr_fields = 2'b10;
        @(negedge clk);
        rx_fatal_err = 1'b0; wr_en = 1'b0; wr_fields = 2'b00;
        chk("R9 error beats write", {rd_data[1], rx_run}, 2'b00);

        // R6 / R10 reset length, abort of an active frame
        do_write(2'b10);
        tx_frame_active = 1'b1;
        do_write(2'b01);
        chk("R6 rd_data in reset", rd_data, 32'h1);
        chk("R10 abort", {tx_idle, tx_bad_crc, local_rst}, 3'b101);
        for (int i = 2; i <= 8; i++) begin
            @(negedge clk);
            chk("R6 reset held", local_rst, 1'b1);
        end
        @(negedge clk);
        chk("R6 reset ends", {local_rst, rd_data[0]}, 2'b00);

        // R7 writes ignored during reset
        do_write(2'b01);
        do_write(2'b10);
        chk("R7 enable write ignored", rd_data, 32'h1);
        do_write(2'b01);
        repeat (5) @(negedge clk);
        chk("R7 cycle 8 still reset", local_rst, 1'b1);
        @(negedge clk);
        chk("R7 no restart", {local_rst, rx_run}, 2'b00);

        // R8 both fields set
        do_write(2'b11);
        chk("R8 reset wins", {local_rst, rd_data[1]}, 2'b10);
        repeat (8) @(negedge clk);
        chk("R8 enable stays clear", rd_data, 32'h0);
        tx_frame_active = 1'b0;

        // Random phase against the model
        for (int c = 0; c < 4000; c++) begin
            chk("R2 R6 readback", rd_data, exp_rd(m_en, m_cnt));
            chk("R3 rx_run", rx_run, m_en);
            chk("R4 R5 tx flags", {tx_run, tx_idle, tx_bad_crc},
                {(m_st == 1), (m_st == 0), m_crc});
            chk("R6 local_rst", local_rst, (m_cnt != 0));
            wr_en           = ($urandom % 5) == 0;
            wr_fields       = 2'($urandom % 4);
            if (wr_fields[0] && ($urandom % 3) != 0) wr_fields[0] = 1'b0;
            tx_fatal_err    = ($urandom % 23) == 0;
            rx_fatal_err    = ($urandom % 29) == 0;
            if (($urandom % 7) == 0) tx_frame_active = ~tx_frame_active;
            tx_eof_ack      = (!tx_idle && !tx_run) && (($urandom % 4) == 0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule